// File: doc/BRIEF.md
# Two-Wire Byte-Addressed Memory Slave

This block answers as a slave on a two-wire serial bus and stands in for a 4096-byte nonvolatile memory. A register array holds the contents. A fast system clock samples the clock and data lines. Each line passes through a two-flop synchronizer and then a short stability filter. The block drives the data line only by pulling it low, through an open-drain enable.

A master opens every command with a start condition. The first byte it sends names the device: a fixed type code, three select bits strapped at the pins, and a direction flag. A write carries a two-byte address and up to a page of data bytes. These bytes land in a page latch and reach the array only at the stop condition, which also starts a timed busy period. A read streams bytes from an internal pointer until the master withholds its acknowledge. A random read is a write that carries only the address, followed by a repeated start with the direction flag set.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the slave leaves SDA released and stays idle. SDA falling while SCL is high (start) begins control-byte decoding from any state, including mid-transfer. SDA rising while SCL is high (stop) returns the slave to idle.
- R2: The control byte is sent MSB first. Bits 7..4 must equal 4'b1010 and bits 3..1 must equal `chipSel`. Bit 0 selects read when 1 and write when 0. On a mismatch the slave does not acknowledge and ignores every bit until the next start or stop.
- R3: The slave acknowledges by holding SDA low through the whole high phase of the ninth clock of a byte.
- R4: In a write, two address bytes follow the control byte, MSB first, and the slave acknowledges each one. Bits 3..0 of the first byte form address bits 11..8, and its bits 7..4 are discarded. The second byte forms address bits 7..0.
- R5: The slave acknowledges every data byte that follows the address. The array takes all latched bytes at the stop, and a busy period of `WR_CYCLES` clocks then begins. A write that carries only the address changes nothing and starts no busy period.
- R6: During the busy period the slave acknowledges nothing, its own control byte included.
- R7: Within a page write, the address bits below the page size (the low 5 bits) count up and wrap inside the 32-byte page, and the higher bits stay fixed.
- R8: A read sends the byte at the pointer MSB first and then moves the pointer up by one. The slave sends another byte each time the master acknowledges. When the master does not acknowledge, SDA stays released until the next start or stop.
- R9: The pointer keeps its value between commands, so a read without an address continues one past the last byte read.
- R10: Sequential reads roll over from address 0xFFF to 0x000.
- R11: With `wrProtect` high at the stop, the slave still acknowledges the address and data bytes, but the array keeps its old contents and no busy period starts.
- R12: A repeated start after data bytes throws the latched bytes away. The array stays unchanged and no busy period starts.
- R13: `sdaPull` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| chipSel | input | 3 | Strapped select bits compared with control-byte bits 3..1 |
| wrProtect | input | 1 | High blocks array updates and the busy period |
| sdaPull | output | 1 | High pulls the open-drain data line low |

## Verification
The assertions assume a well-formed bus. SDA moves while SCL is high only to make a start or a stop. Every SCL and SDA level lasts longer than the synchronizer plus the filter. `wrProtect` stays steady around each stop. The bench plays a bit-banged master in which each SCL phase lasts eight system clocks or more and SDA changes only in the middle of a low phase. It also holds the protect input steady across whole commands, so no check depends on a race between the line filters and the control logic.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } eeState_t;

  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic rxShift;    // shift one received bit into the byte register
    logic setHi;      // take high address bits from the received byte
    logic setLo;      // take low address bits from the received byte
    logic latchData;  // park received byte in the page latch
    logic loadTx;     // fetch array byte at pointer, bump pointer
    logic commit;     // copy page latch into array, start busy period
    logic dropPage;   // clear page latch valid bits
  } eeStrobe_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/ee_line_filter.sv
module ee_line_filter #(
  parameter int LINES     = 2,
  parameter int FILT_CLKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  output logic [LINES-1:0] lineOut
);

  localparam int CNT_W = $clog2(FILT_CLKS + 1);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic             syncA;
    logic             syncB;
    logic [CNT_W-1:0] holdCnt;
    logic             level;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA   <= 1'b1;
        syncB   <= 1'b1;
        holdCnt <= '0;
        level   <= 1'b1;
      end else begin
        syncA <= lineIn[g];
        syncB <= syncA;
        if (syncB != level) begin
          if (holdCnt == CNT_W'(FILT_CLKS - 1)) begin
            level   <= syncB;
            holdCnt <= '0;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end else begin
          holdCnt <= '0;
        end
      end
    end

    assign lineOut[g] = level;
  end

endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [2:0] chipSel,
  input  logic       wrProtect,
  input  logic [7:0] rxByte,
  input  logic [7:0] txByte,
  input  logic       busy,
  input  logic       pageDirty,
  output eeStrobe_t  strb,
  output logic       pull
);

  logic       sclQ;
  logic       sdaQ;
  eeState_t   st;
  logic [3:0] bitCnt;
  logic       inAck;
  logic       refresh;
  logic       mAck;

  logic sclRise;
  logic sclFall;
  logic startDet;
  logic stopDet;
  logic ackEnd;
  logic rxPhase;
  logic devHit;
  logic [2:0] txIdx;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;
  assign ackEnd   = sclFall & inAck;
  assign rxPhase  = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
  assign devHit   = (rxByte[7:4] == DEV_CODE) && (rxByte[3:1] == chipSel) && !busy;
  assign txIdx    = 3'(4'd7 - bitCnt);

  always_comb begin
    strb           = '0;
    strb.rxShift   = rxPhase && sclRise && !inAck && (bitCnt < 4'd8);
    strb.setHi     = ackEnd && (st == ST_AHI);
    strb.setLo     = ackEnd && (st == ST_ALO);
    strb.latchData = ackEnd && (st == ST_WDAT);
    strb.loadTx    = ackEnd && (((st == ST_DEV) && rxByte[0]) || ((st == ST_RDAT) && mAck));
    strb.commit    = stopDet && pageDirty && !wrProtect;
    strb.dropPage  = startDet || stopDet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      st      <= ST_IDLE;
      bitCnt  <= '0;
      inAck   <= 1'b0;
      refresh <= 1'b0;
      mAck    <= 1'b0;
      pull    <= 1'b0;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      if (startDet) begin
        st      <= ST_DEV;
        bitCnt  <= '0;
        inAck   <= 1'b0;
        refresh <= 1'b0;
        pull    <= 1'b0;
      end else if (stopDet) begin
        st      <= ST_IDLE;
        bitCnt  <= '0;
        inAck   <= 1'b0;
        refresh <= 1'b0;
        pull    <= 1'b0;
      end else begin
        if (refresh) begin
          refresh <= 1'b0;
          if (bitCnt < 4'd8) pull <= ~txByte[txIdx];
        end
        case (st)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (sclRise && !inAck && (bitCnt < 4'd8)) bitCnt <= bitCnt + 1'b1;
            if (sclFall && !inAck && (bitCnt == 4'd8)) begin
              if ((st != ST_DEV) || devHit) begin
                pull  <= 1'b1;
                inAck <= 1'b1;
              end else begin
                st <= ST_SKIP;
              end
            end
            if (ackEnd) begin
              pull   <= 1'b0;
              inAck  <= 1'b0;
              bitCnt <= '0;
              case (st)
                ST_DEV: begin
                  if (rxByte[0]) begin
                    st      <= ST_RDAT;
                    refresh <= 1'b1;
                  end else begin
                    st <= ST_AHI;
                  end
                end
                ST_AHI:  st <= ST_ALO;
                default: st <= ST_WDAT;
              endcase
            end
          end
          ST_RDAT: begin
            if (sclRise) begin
              if (!inAck) bitCnt <= bitCnt + 1'b1;
              else        mAck   <= ~sdaF;
            end
            if (sclFall && !inAck) begin
              if (bitCnt == 4'd8) begin
                pull  <= 1'b0;
                inAck <= 1'b1;
              end else begin
                refresh <= 1'b1;
              end
            end
            if (ackEnd) begin
              inAck <= 1'b0;
              if (mAck) begin
                bitCnt  <= '0;
                refresh <= 1'b1;
              end else begin
                st   <= ST_SKIP;
                pull <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R13: the data line is never moved while the clock is high
  a_r13_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclF && sclQ) |-> $stable(pull));

  // R6: no acknowledge of the control byte while the write cycle runs
  a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    ((st == ST_DEV) && busy) |-> !pull);

  // R1: stop returns to idle with the line released
  a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> ((st == ST_IDLE) && !pull));

  // R1: start restarts control-byte decoding
  a_r1_start_decodes: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> ((st == ST_DEV) && (bitCnt == 4'd0)));

  // R11: a busy period only follows a stop without write protection
  a_r11_busy_needs_unprotected_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopDet && !wrProtect));

endmodule

// File: rtl/ee_data.sv
module ee_data
  import ee_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaF,
  input  eeStrobe_t  strb,
  output logic [7:0] rxByte,
  output logic [7:0] txByte,
  output logic       busy,
  output logic       pageDirty
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam int BUSY_W = $clog2(WR_CYCLES + 1);

  logic [7:0]          mem     [DEPTH];
  logic [7:0]          pageBuf [PAGE_N];
  logic [PAGE_N-1:0]   pageMask;
  logic [ADDR_W-1:0]   ptr;
  logic [BUSY_W-1:0]   busyCnt;
  logic [ADDR_W-PAGE_W-1:0] pageBase;
  logic [PAGE_W-1:0]   pageIdx;

  assign pageBase  = ptr[ADDR_W-1:PAGE_W];
  assign pageIdx   = ptr[PAGE_W-1:0];
  assign pageDirty = |pageMask;
  assign busy      = (busyCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte   <= '0;
      txByte   <= '0;
      ptr      <= '0;
      pageMask <= '0;
      busyCnt  <= '0;
    end else begin
      if (strb.rxShift) rxByte <= {rxByte[6:0], sdaF};
      if (strb.setHi)   ptr[ADDR_W-1:8] <= rxByte[HI_W-1:0];
      if (strb.setLo)   ptr[7:0] <= rxByte;
      if (strb.latchData) begin
        pageMask[pageIdx]   <= 1'b1;
        ptr[PAGE_W-1:0]     <= pageIdx + 1'b1;
      end
      if (strb.loadTx) begin
        txByte <= mem[ptr];
        ptr    <= ptr + 1'b1;
      end
      if (strb.dropPage) pageMask <= '0;
      if (strb.commit)   busyCnt  <= BUSY_W'(WR_CYCLES);
      else if (busy)     busyCnt  <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.latchData) pageBuf[pageIdx] <= rxByte;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_N; i++) begin
      if (strb.commit && pageMask[i]) mem[{pageBase, PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  // R7: storing a page byte never moves the page base
  a_r7_page_base_fixed: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchData |=> (pageBase == $past(pageBase)));

  // R5: a commit opens the busy period
  a_r5_commit_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> busy);

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import ee_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int FILT_CLKS = 3,
  parameter int WR_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       wrProtect,
  output logic       sdaPull
);

  logic [1:0] linesF;
  eeStrobe_t  strb;
  logic [7:0] rxByte;
  logic [7:0] txByte;
  logic       busy;
  logic       pageDirty;

  ee_line_filter #(.LINES(2), .FILT_CLKS(FILT_CLKS)) u_filter (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  ({sclIn, sdaIn}),
    .lineOut (linesF)
  );

  ee_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclF      (linesF[1]),
    .sdaF      (linesF[0]),
    .chipSel   (chipSel),
    .wrProtect (wrProtect),
    .rxByte    (rxByte),
    .txByte    (txByte),
    .busy      (busy),
    .pageDirty (pageDirty),
    .strb      (strb),
    .pull      (sdaPull)
  );

  ee_data #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .sdaF      (linesF[0]),
    .strb      (strb),
    .rxByte    (rxByte),
    .txByte    (txByte),
    .busy      (busy),
    .pageDirty (pageDirty)
  );

endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;

  localparam int WR = 2000;
  localparam int Q  = 8;
  localparam logic [2:0] SEL    = 3'b101;
  localparam logic [7:0] CTRL_W = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] CTRL_R = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wp   = 1'b0;
  logic sdaPull;
  logic sdaBus;
  assign sdaBus = sdaM & ~sdaPull;

  serial_eeprom_slave #(.WR_CYCLES(WR)) u_serial_eeprom_slave (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclM),
    .sdaIn     (sdaBus),
    .chipSel   (SEL),
    .wrProtect (wp),
    .sdaPull   (sdaPull)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural model state
  logic [7:0] refMem [int];
  int refPtr  = 0;
  int busyEnd = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sdaM = 1'b0; tick(2*Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sdaM = 1'b1; tick(2*Q);
  endtask

  // one bit slot; pull compared on every clock of the high phase
  task automatic busBit(input bit v, input bit expPull, output bit seen, output bit ok);
    ok = 1'b1;
    seen = 1'b1;
    sdaM = v; tick(Q);
    sclM = 1'b1;
    for (int k = 0; k < 2*Q; k++) begin
      @(negedge clk);
      if (sdaPull !== expPull) ok = 1'b0;
      if (k == Q) seen = sdaBus;
    end
    sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string what);
    bit seen, ok, allOk;
    allOk = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      busBit(b[i], 1'b0, seen, ok);
      allOk &= ok;
    end
    check(allOk, "R13 slave quiet while master sends", int'(allOk), 1);
    busBit(1'b1, expAck, seen, ok);
    check(ok && (seen == !expAck), {what, " (R3 ack level)"}, int'(seen), int'(!expAck));
  endtask

  task automatic recvByte(input logic [7:0] exp, input bit ackIt, input string what);
    bit seen, ok, allOk;
    logic [7:0] got;
    allOk = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, !exp[i], seen, ok);
      got[i] = seen;
      allOk &= ok;
    end
    check(got == exp, what, int'(got), int'(exp));
    check(allOk, "R13 read bits steady while SCL high", int'(allOk), 1);
    busBit(!ackIt, 1'b0, seen, ok);
    check(ok, "R8 line released during master ack", int'(ok), 1);
  endtask

  task automatic writeOp(input int addr, input logic [7:0] d[$], input string what);
    bit expA;
    int p;
    logic [7:0] pend [int];
    busStart();
    expA = (cyc >= busyEnd);
    sendByte(CTRL_W, expA, {what, " control"});
    if (!expA) begin busStop(); return; end
    sendByte(addr[15:8], 1'b1, {what, " R4 address high"});
    sendByte(addr[7:0], 1'b1, {what, " R4 address low"});
    p = addr & 'hFFF;
    foreach (d[k]) begin
      sendByte(d[k], 1'b1, {what, " R5 data"});
      pend[p] = d[k];
      p = (p & ~31) | ((p + 1) & 31);
    end
    busStop();
    refPtr = p;
    if (d.size() > 0 && !wp) begin
      foreach (pend[a]) refMem[a] = pend[a];
      busyEnd = cyc + WR + 8;
    end
  endtask

  task automatic readOp(input int addr, input int n, input string what);
    bit expA;
    if (addr >= 0) begin
      busStart();
      expA = (cyc >= busyEnd);
      sendByte(CTRL_W, expA, {what, " dummy-write control"});
      if (!expA) begin busStop(); return; end
      sendByte(8'(addr >> 8), 1'b1, {what, " R4 address high"});
      sendByte(8'(addr), 1'b1, {what, " R4 address low"});
      refPtr = addr & 'hFFF;
    end
    busStart();
    expA = (cyc >= busyEnd);
    sendByte(CTRL_R, expA, {what, " read control"});
    if (!expA) begin busStop(); return; end
    for (int k = 0; k < n; k++) begin
      recvByte(refMem[refPtr], k < n - 1, what);
      refPtr = (refPtr + 1) & 'hFFF;
    end
    busStop();
  endtask

  task automatic waitWrite();
    tick(WR + 300);
  endtask

  initial begin
    bit ok;
    tick(5);
    rstN = 1'b1;
    ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sdaPull !== 1'b0) ok = 1'b0;
    end
    check(ok, "R1 line released after reset", int'(sdaPull), 0);

    // byte write, then control byte during the busy period
    writeOp('h0123, '{8'hA5}, "R5 byte write");
    busStart();
    check(cyc < busyEnd, "R6 still inside write cycle", cyc, busyEnd);
    sendByte(CTRL_W, 1'b0, "R6 no ack while busy");
    busStop();
    waitWrite();
    readOp('h0123, 1, "R8 random read");

    // control byte mismatches
    busStart();
    sendByte({4'b1011, SEL, 1'b0}, 1'b0, "R2 wrong device code");
    sendByte(8'h00, 1'b0, "R2 ignored after mismatch");
    busStop();
    busStart();
    sendByte({4'b1010, 3'b010, 1'b0}, 1'b0, "R2 wrong select bits");
    busStop();

    // current address read
    writeOp('h0040, '{8'h10, 8'h20, 8'h30}, "R5 page write");
    waitWrite();
    readOp('h0040, 1, "R9 setup read");
    readOp(-1, 1, "R9 current address read");

    // write protect
    writeOp('h0055, '{8'h11}, "R11 setup");
    waitWrite();
    wp = 1'b1;
    writeOp('h0055, '{8'h3C}, "R11 protected write");
    readOp('h0055, 1, "R11 array unchanged and no busy");
    wp = 1'b0;

    // page wrap
    writeOp('h0300, '{8'h5A}, "R7 neighbour");
    waitWrite();
    writeOp('h02FC, '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5}, "R7 wrapping page write");
    waitWrite();
    readOp('h02FC, 4, "R7 page tail");
    readOp('h02E0, 2, "R7 wrapped to page start");
    readOp('h0300, 1, "R7 next page untouched");

    // sequential read across the end of the array
    writeOp('h0FFF, '{8'h77}, "R10 last byte");
    waitWrite();
    writeOp('h0000, '{8'h88}, "R10 first byte");
    waitWrite();
    readOp('h0FFF, 2, "R10 rollover read");

    // high nibble of the address is discarded
    writeOp('hF0C4, '{8'h5E}, "R4 high nibble set");
    waitWrite();
    readOp('h00C4, 1, "R4 high nibble discarded");

    // repeated start aborts pending data
    writeOp('h0200, '{8'h42, 8'h43}, "R12 setup");
    waitWrite();
    busStart();
    sendByte(CTRL_W, 1'b1, "R12 control");
    sendByte(8'h02, 1'b1, "R12 address high");
    sendByte(8'h00, 1'b1, "R12 address low");
    sendByte(8'h99, 1'b1, "R12 data before abort");
    busStart();
    sendByte(CTRL_R, 1'b1, "R12 no write cycle after abort");
    recvByte(8'h43, 1'b0, "R12 pointer after aborted byte");
    busStop();
    refPtr = 'h0202;
    readOp('h0200, 1, "R12 byte kept");

    // address-only write leaves no busy period
    writeOp('h0010, '{}, "R5 address-only write");
    readOp('h0040, 1, "R5 no busy after address-only write");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule